// File: doc/BRIEF.md
# Zero-Voltage Switching Detector

This block watches one power switch and decides, once per turn-on command, whether that turn-on happened under zero-voltage conditions. It takes two asynchronous inputs. The first is the gate command. The second is a digital flag from an external comparator that is high while the switch's drain-source voltage is negative, which means the switch is conducting in reverse (third quadrant).

Both inputs pass through two-flop synchronizers. The block then keeps a count of how many consecutive clocks the negative-voltage flag has stayed high. When the synchronized command rises, that count is compared with a run-time minimum. If the flag is still high at that moment and the run was long enough, the block sends a single confirmation pulse. The pulse starts after a run-time delay and lasts a run-time width. If the switch was hard-switched, partly hard-switched, or in reverse conduction for too short a time, no pulse is sent.

A controller for a soft-switching converter can use this pulse as per-cycle feedback to adjust its dead time or current.

Top module: `zvd_detector`

## Requirements
- R1: While rst_ni is low, pulse_o is low at once, and the run counter, the pending flag and the pulse timer are all cleared.
- R2: in_i and neg_i each pass through two flops. A turn-on decision is taken only on a low-to-high change of the synchronized in_i. A steady high level or a falling edge starts nothing, so holding in_i high gives at most one pulse.
- R3: A turn-on qualifies when both of these hold: neg_i is sampled high on the clock edge that first samples in_i high, and neg_i was also high on each of the at least thr_i clock edges just before that one. With thr_i = 0, only the sample on the turn-on edge counts.
- R4: If the run of high neg_i samples before the turn-on edge is one shorter than thr_i, no pulse is sent. Any low sample resets the run to zero.
- R5: If neg_i is low on the turn-on edge (hard or partial hard switching), no pulse is sent. This holds even if neg_i was high earlier. A switch that is hard-switched on every cycle keeps pulse_o low all the time.
- R6: Number the clock edge that first samples in_i high as edge 0. For a qualified turn-on with the block idle, pulse_o is high after edges dly_i+2 through dly_i+wid_i+1. dly_i = 0 is allowed.
- R7: The pulse lasts exactly wid_i clocks. wid_i = 0 is treated as 1.
- R8: The run counter saturates at thr_i instead of wrapping. A negative-voltage run of any length, for example 300 clocks with an 8-bit counter, still qualifies.
- R9: A turn-on that arrives while a pulse is delayed or active has its decision held. Only the latest such decision is kept. After the current pulse ends, pulse_o stays low for exactly one clock (the gap clock). A held qualified decision then starts its pulse dly_i+1 clocks after that gap clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_i | input | 1 | Gate turn-on command, asynchronous |
| neg_i | input | 1 | Comparator flag, high while drain-source voltage is below zero; asynchronous |
| thr_i | input | CNT_W | Minimum reverse-conduction run, in clocks |
| dly_i | input | CNT_W | Delay from the turn-on decision to the pulse, in clocks |
| wid_i | input | CNT_W | Pulse width in clocks (0 is treated as 1) |
| pulse_o | output | 1 | Zero-voltage confirmation pulse |

## Verification
Every result is timed from the clock edge that first samples in_i high, counted as edge 0. The two synchronizer flops and the edge register put the decision in the clock after edge 1. The delay timer is loaded on edge 2, so a pulse from an idle block is due after edge dly_i+2 and lasts wid_i clocks. A held turn-on is due dly_i+1 clocks after the single gap clock. The bench changes inputs only on falling edges and reads pulse_o after each falling edge. It compares the index of the first high sample and the number of high samples against values derived from these counts. For a held turn-on it compares a whole per-clock bitmask.

// File: rtl/zvd_pkg.sv
package zvd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_GAP    = 2'd3
  } zvd_state_e;
endpackage

// File: rtl/zvd_sync.sv
module zvd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/zvd_run_cnt.sv
module zvd_run_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             neg_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             qual_o
);
  logic [CNT_W-1:0] cnt_q;

  // Consecutive high samples before the current cycle, saturating at thr_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!neg_i)         cnt_q <= '0;
    else if (cnt_q < thr_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = neg_i && (cnt_q >= thr_i);

  AST_RUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_i |=> cnt_q == '0); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg_i && cnt_q != '0) |=> cnt_q != '0); // R8
endmodule

// File: rtl/zvd_pulse_gen.sv
module zvd_pulse_gen
  import zvd_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             qual_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             pulse_o
);
  zvd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] wid_m1;
  logic             hit;

  assign wid_m1 = (wid_i == '0) ? '0 : wid_i - 1'b1;
  assign hit    = trig_i && qual_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE, ST_GAP: begin
        if (pend_q || hit) begin
          pend_d = pend_q && hit;
          if (dly_i == '0) begin
            state_d = ST_ACTIVE;
            cnt_d   = wid_m1;
          end else begin
            state_d = ST_DELAY;
            cnt_d   = dly_i - 1'b1;
          end
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_DELAY: begin
        if (trig_i) pend_d = qual_i;
        if (cnt_q == '0) begin
          state_d = ST_ACTIVE;
          cnt_d   = wid_m1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (trig_i) pend_d = qual_i;
        if (cnt_q == '0) state_d = ST_GAP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign pulse_o = (state_q == ST_ACTIVE);

  AST_HARD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !pend_q && trig_i && !qual_i) |=> state_q == ST_IDLE); // R5
  AST_DELAY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !pend_q && hit && dly_i != '0) |=> state_q == ST_DELAY); // R6
  AST_WIDTH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pulse_o) && $stable(wid_i)) |-> cnt_q == wid_m1); // R7
  AST_GAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && cnt_q == '0) |=> !pulse_o); // R9
endmodule

// File: rtl/zvd_detector.sv
module zvd_detector #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic             neg_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             pulse_o
);
  logic [1:0] sync_q;
  logic       in_s, neg_s, in_d_q, trig, qual;

  zvd_sync #(.WIDTH(2), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({neg_i, in_i}),
    .q_o    (sync_q)
  );
  assign in_s  = sync_q[0];
  assign neg_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_d_q <= 1'b0;
    else         in_d_q <= in_s;
  end
  assign trig = in_s && !in_d_q;

  zvd_run_cnt #(.CNT_W(CNT_W)) i_run_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .neg_i  (neg_s),
    .thr_i  (thr_i),
    .qual_o (qual)
  );

  zvd_pulse_gen #(.CNT_W(CNT_W)) i_pulse_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig),
    .qual_i  (qual),
    .dly_i   (dly_i),
    .wid_i   (wid_i),
    .pulse_o (pulse_o)
  );

  AST_EDGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> !trig); // R2
  AST_RST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pulse_o); // R1
endmodule

// File: tb/test_zvd_detector.sv
`timescale 1ns/1ps
module test_zvd_detector;
  localparam int CNT_W = 8;
  localparam int NV    = 9;
  // thr, dly, wid, lead, neg_at_edge, expect_pulse
  localparam int VEC [NV][6] = '{
    '{4, 2, 3,   4, 1, 1},  // R3 exact threshold
    '{4, 2, 3,   3, 1, 0},  // R4 one short
    '{4, 2, 3,   6, 0, 0},  // R5 partial hard switching
    '{3, 0, 2,   5, 1, 1},  // R6 zero delay
    '{2, 5, 1,   2, 1, 1},  // R7 width one
    '{5, 1, 4, 300, 1, 1},  // R8 long run
    '{0, 1, 2,   0, 1, 1},  // R3 zero threshold
    '{1, 3, 0,   1, 1, 1},  // R7 width zero as one
    '{6, 4, 5,   0, 0, 0}   // R5 hard switching
  };

  logic clk = 1'b0, rst_ni = 1'b0, in_i = 1'b0, neg_i = 1'b0;
  logic [CNT_W-1:0] thr_i = '0, dly_i = '0, wid_i = 8'd1;
  logic pulse_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  zvd_detector #(.CNT_W(CNT_W)) i_zvd_detector (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in_i), .neg_i(neg_i),
    .thr_i(thr_i), .dly_i(dly_i), .wid_i(wid_i), .pulse_o(pulse_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    int wd, first, hits;
    thr_i = 8'(VEC[i][0]); dly_i = 8'(VEC[i][1]); wid_i = 8'(VEC[i][2]);
    in_i = 1'b0; neg_i = 1'b0;
    repeat (8) @(negedge clk);
    wd = (VEC[i][2] == 0) ? 1 : VEC[i][2];
    if (VEC[i][3] > 0) begin
      neg_i = 1'b1;
      repeat (VEC[i][3]) @(negedge clk);
    end
    in_i = 1'b1; neg_i = VEC[i][4][0];
    first = -1; hits = 0;
    for (int k = 0; k < VEC[i][1] + wd + 8; k++) begin
      @(negedge clk);
      if (pulse_o) begin
        hits++;
        if (first < 0) first = k;
      end
    end
    check($sformatf("R3/R4/R5/R6 vec%0d start", i), first, VEC[i][5] ? VEC[i][1] + 2 : -1);
    check($sformatf("R7/R2 vec%0d width", i), hits, VEC[i][5] ? wd : 0);
    in_i = 1'b0; neg_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [23:0] obs;
    int hits;
    repeat (3) @(negedge clk);
    check("R1 reset low", int'(pulse_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: turn-on during active pulse is held until after the gap clock
    thr_i = 8'd2; dly_i = 8'd3; wid_i = 8'd4;
    repeat (8) @(negedge clk);
    neg_i = 1'b1;
    repeat (3) @(negedge clk);
    in_i = 1'b1;
    obs = '0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      obs[k] = pulse_o;
      if (k == 2) in_i = 1'b0;
      if (k == 4) in_i = 1'b1;
    end
    check("R9 held turn-on mask", int'(obs), int'(24'h01E1E0));
    in_i = 1'b0; neg_i = 1'b0;

    // R5: repeated hard switching keeps output low
    thr_i = 8'd0; dly_i = 8'd0; wid_i = 8'd2;
    hits = 0;
    for (int c = 0; c < 5; c++) begin
      in_i = 1'b1;
      repeat (4) begin @(negedge clk); hits += int'(pulse_o); end
      in_i = 1'b0;
      repeat (4) begin @(negedge clk); hits += int'(pulse_o); end
    end
    check("R5 repeated hard low", hits, 0);

    // R1: reset in the middle of a pulse
    wid_i = 8'd5;
    repeat (4) @(negedge clk);
    in_i = 1'b1; neg_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 pulse active before reset", int'(pulse_o), 1);
    rst_ni = 1'b0; in_i = 1'b0; neg_i = 1'b0;
    #1;
    check("R1 async clear", int'(pulse_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    hits = 0;
    repeat (10) begin @(negedge clk); hits += int'(pulse_o); end
    check("R1 low after reset", hits, 0);

    done = 1'b1;
    finish_run();
  end
endmodule